// File: doc/BRIEF.md
# Adaptive Clock Rate Tracking Controller

This block is the digital heart of a loop that sets a system clock to the fastest rate a slow combinational path can still meet, with a margin. It emits a test signal that inverts on every clock edge. Outside the block, that signal runs through a delay line. The delay line copies the critical path and adds a safety margin, and the delayed signal comes back on a separate input. The block folds the returned level against its own toggle state. The result is a single "arrived late" bit, which a checker flop captures on the system clock.

That checker flop is pushed on purpose toward its metastable point. Its output therefore passes through a chain of synchronizing flops before it selects a direction. A late sample steps a saturating code down, toward a slower clock. An on-time sample steps the code up, toward a faster clock. The code drives a DAC, the DAC drives a VCO, and the VCO produces the system clock. Steps are spaced so that each decision reflects the previous step. At equilibrium the code settles into alternating between two neighbouring values, and a lock flag reports this once enough direction reversals have come in a row.

Top module: `adaptive_clk_tracker`

## Requirements
- R1: `test_out` is 0 while reset is held, and it inverts on every rising clock edge after reset is released.
- R2: At each clock edge the block forms a lateness bit, which is 1 when `delayed_in` differs from the level `test_out` has just before that edge. A 1 that reaches the counter lowers `dac_code` by one code. A 0 raises it by one code.
- R3: The lateness bit passes through the checker flop and then `SYNC_STAGES` synchronizer flops (minimum 2). The code moves by at most one code per step, and steps come exactly every `SYNC_STAGES+2` cycles. With 2 stages, the first step comes on the 4th edge after reset release and uses the bit sampled on the 1st edge.
- R4: `dac_code` saturates at 0 and at `2**CODE_W-1`. It never wraps.
- R5: A synchronous active-high `rst` loads `dac_code` with `SAFE_CODE`, clears `locked`, and clears the toggle and synchronizer flops.
- R6: While `en` is low, `dac_code` and `locked` hold their values.
- R7: `locked` rises after `LOCK_COUNT` consecutive steps, each in the opposite direction to the step before it. Any step in the same direction as the previous one clears `locked`.
- R8: In a closed loop with a fixed path delay, `dac_code` converges from `SAFE_CODE` and then dithers between the two codes that straddle the delay threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (the VCO output) |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows code steps when high |
| delayed_in | input | 1 | Test signal returned through the external path-replica delay |
| test_out | output | 1 | Toggling test signal sent to the delay line |
| dac_code | output | CODE_W | Frequency code for the DAC; higher is faster |
| locked | output | 1 | High after LOCK_COUNT back-to-back direction reversals |

## Verification
The bench builds the block with a 6-bit code, a safe code of 8, two synchronizer stages and a lock count of 4. These values keep both saturation ends within a few hundred cycles. The 4-cycle step spacing makes the first down step land on an exact edge after reset. A behavioural delay model turns the code into a period and compares it with a fixed path delay. The equilibrium then falls between codes 45 and 46, well inside the range, so convergence, dithering, lock, and loss of lock can all be observed in one short run.

// File: rtl/clk_trk_pkg.sv
package clk_trk_pkg;

    // Direction of one code step; the encoding equals the lateness bit.
    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_dir_e;

    function automatic int unsigned sync_depth(input int unsigned requested);
        return (requested < 2) ? 2 : requested;
    endfunction

endpackage

// File: rtl/trk_probe.sv
// Toggle source, lateness normalization and the timing checker flop.
module trk_probe (
    input  logic clk,
    input  logic rst,
    input  logic delayed_in,
    output logic test_out,
    output logic sample_out
);
    typedef struct packed {
        logic toggle;
        logic check;
    } probe_state_t;

    probe_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.toggle = ~state_q.toggle;
        // Equal levels: the edge arrived in time. Different: still the old phase.
        state_d.check  = delayed_in ^ state_q.toggle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign test_out   = state_q.toggle;
    assign sample_out = state_q.check;
endmodule

// File: rtl/trk_sync.sv
// Synchronizer chain behind the near-metastable checker flop.
module trk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d.chain[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            state_d.chain[i] = state_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dout = state_q.chain[STAGES-1];
endmodule

// File: rtl/trk_stepper.sv
// Paced saturating up/down code counter.
module trk_stepper
    import clk_trk_pkg::*;
#(
    parameter int unsigned CODE_W    = 8,
    parameter int unsigned SAFE_CODE = 16,
    parameter int unsigned STEP_GAP  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  step_dir_e         dir,
    output logic [CODE_W-1:0] code,
    output logic              fire
);
    localparam int unsigned TIMER_W  = (STEP_GAP > 1) ? $clog2(STEP_GAP) : 1;
    localparam logic [TIMER_W-1:0] TIMER_END = TIMER_W'(STEP_GAP - 1);
    localparam logic [CODE_W-1:0]  CODE_MAX  = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0]  CODE_INIT = CODE_W'(SAFE_CODE);

    typedef struct packed {
        logic [TIMER_W-1:0] timer;
        logic [CODE_W-1:0]  code;
    } step_state_t;

    step_state_t state_d, state_q;
    logic        tick;

    always_comb begin
        state_d = state_q;
        tick    = (state_q.timer == TIMER_END);
        fire    = tick & en;

        state_d.timer = tick ? '0 : state_q.timer + 1'b1;

        if (fire) begin
            if (dir == STEP_DOWN) begin
                if (state_q.code != '0) begin
                    state_d.code = state_q.code - 1'b1;
                end
            end else begin
                if (state_q.code != CODE_MAX) begin
                    state_d.code = state_q.code + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.timer <= '0;
            state_q.code  <= CODE_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign code = state_q.code;
endmodule

// File: rtl/trk_lock.sv
// Counts back-to-back direction reversals of applied steps.
module trk_lock
    import clk_trk_pkg::*;
#(
    parameter int unsigned LOCK_COUNT = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  step_dir_e dir,
    output logic      locked
);
    localparam int unsigned CNT_W = $clog2(LOCK_COUNT + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOCK_COUNT);

    typedef struct packed {
        logic             seen;
        step_dir_e        last;
        logic [CNT_W-1:0] reversals;
    } lock_state_t;

    lock_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (fire) begin
            state_d.seen = 1'b1;
            state_d.last = dir;
            if (state_q.seen && (dir != state_q.last)) begin
                if (state_q.reversals != CNT_TOP) begin
                    state_d.reversals = state_q.reversals + 1'b1;
                end
            end else begin
                state_d.reversals = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.seen      <= 1'b0;
            state_q.last      <= STEP_UP;
            state_q.reversals <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign locked = (state_q.reversals == CNT_TOP);
endmodule

// File: rtl/adaptive_clk_tracker.sv
module adaptive_clk_tracker
    import clk_trk_pkg::*;
#(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned SAFE_CODE   = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LOCK_COUNT  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              delayed_in,
    output logic              test_out,
    output logic [CODE_W-1:0] dac_code,
    output logic              locked
);
    localparam int unsigned SYNC_USED = sync_depth(SYNC_STAGES);
    // Checker flop + synchronizer + one cycle of code settling in the loop.
    localparam int unsigned STEP_GAP  = SYNC_USED + 2;

    logic      late_raw;
    logic      late_sync;
    logic      step_fire;
    step_dir_e step_dir;

    trk_probe i_probe (
        .clk        (clk),
        .rst        (rst),
        .delayed_in (delayed_in),
        .test_out   (test_out),
        .sample_out (late_raw)
    );

    trk_sync #(
        .STAGES (SYNC_USED)
    ) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (late_raw),
        .dout (late_sync)
    );

    assign step_dir = step_dir_e'(late_sync);

    trk_stepper #(
        .CODE_W    (CODE_W),
        .SAFE_CODE (SAFE_CODE),
        .STEP_GAP  (STEP_GAP)
    ) i_stepper (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .dir  (step_dir),
        .code (dac_code),
        .fire (step_fire)
    );

    trk_lock #(
        .LOCK_COUNT (LOCK_COUNT)
    ) i_lock (
        .clk    (clk),
        .rst    (rst),
        .fire   (step_fire),
        .dir    (step_dir),
        .locked (locked)
    );
endmodule

// File: rtl/trk_checker.sv
module trk_checker #(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned SAFE_CODE   = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              test_out,
    input logic [CODE_W-1:0] dac_code,
    input logic              locked
);
    localparam int unsigned GAP = ((SYNC_STAGES < 2) ? 2 : SYNC_STAGES) + 2;
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] prev_code_q;
    logic [7:0]        since_q;

    always_ff @(posedge clk) begin
        prev_code_q <= dac_code;
        if (rst) begin
            since_q <= 8'hFF;
        end else if (dac_code != prev_code_q) begin
            since_q <= 8'd0;
        end else if (since_q != 8'hFF) begin
            since_q <= since_q + 8'd1;
        end
    end

    assert_reset_state_R5: assert property (@(posedge clk)
        rst |=> (dac_code == CODE_W'(SAFE_CODE)) && !locked && !test_out);

    assert_toggle_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> test_out != $past(test_out));

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (dac_code == $past(dac_code)) ||
                 (dac_code == CODE_W'($past(dac_code) + 1'b1)) ||
                 (dac_code == CODE_W'($past(dac_code) - 1'b1)));

    assert_step_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (dac_code != prev_code_q) |-> (since_q >= 8'(GAP - 1)));

    assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (rst)
        (dac_code == CODE_MAX) |=> dac_code != '0);

    assert_no_wrap_bottom_R4: assert property (@(posedge clk) disable iff (rst)
        (dac_code == '0) |=> dac_code != CODE_MAX);

    assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dac_code) && $stable(locked));

    assert_lock_on_step_R7: assert property (@(posedge clk) disable iff (rst)
        !locked |=> !locked || (dac_code != $past(dac_code)));
endmodule

bind adaptive_clk_tracker trk_checker #(
    .CODE_W      (CODE_W),
    .SAFE_CODE   (SAFE_CODE),
    .SYNC_STAGES (SYNC_STAGES)
) i_trk_checker (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .test_out (test_out),
    .dac_code (dac_code),
    .locked   (locked)
);

// File: tb/test_adaptive_clk_tracker.sv
module test_adaptive_clk_tracker;
    localparam int CODE_W   = 6;
    localparam int SAFE     = 8;
    localparam int SYNC     = 2;
    localparam int LOCK_N   = 4;
    localparam int GAP      = SYNC + 2;
    localparam int CODE_TOP = (1 << CODE_W) - 1;
    localparam int DELAY_PS = 1100;   // path replica plus margin

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b1;
    logic              delayed_in = 1'b0;
    logic              test_out;
    logic [CODE_W-1:0] dac_code;
    logic              locked;

    int mode = 1;          // 0: delay model, 1: always late, 2: always on time
    int tests = 0;
    int fails = 0;
    int bad_steps = 0;
    int prev_code = SAFE;
    int gap_cnt = 99;
    bit done = 1'b0;

    adaptive_clk_tracker #(
        .CODE_W      (CODE_W),
        .SAFE_CODE   (SAFE),
        .SYNC_STAGES (SYNC),
        .LOCK_COUNT  (LOCK_N)
    ) i_adaptive_clk_tracker (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .delayed_in (delayed_in),
        .test_out   (test_out),
        .dac_code   (dac_code),
        .locked     (locked)
    );

    always #4 clk = ~clk;

    // Environment: delay line returning the toggle; period shrinks as code grows.
    always @(negedge clk) begin
        int period_ps;
        bit late;
        period_ps = 2000 - 20 * int'(dac_code);
        case (mode)
            1:       late = 1'b1;
            2:       late = 1'b0;
            default: late = (DELAY_PS > period_ps);
        endcase
        delayed_in <= late ? ~test_out : test_out;
    end

    // Step-size and step-spacing monitor (R3).
    always @(negedge clk) begin
        if (rst) begin
            prev_code = int'(dac_code);
            gap_cnt   = 99;
        end else begin
            gap_cnt++;
            if (int'(dac_code) != prev_code) begin
                if ((int'(dac_code) - prev_code > 1) || (prev_code - int'(dac_code) > 1) ||
                    (gap_cnt < GAP)) begin
                    bad_steps++;
                end
                gap_cnt = 0;
            end
            prev_code = int'(dac_code);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(input int m, input bit enable);
        mode = m;
        en   = enable;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        mode = 2;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(test_out == 1'b0, "R5 test_out in reset", int'(test_out), 0);
        check(int'(dac_code) == SAFE, "R5 code in reset", int'(dac_code), SAFE);
        check(locked == 1'b0, "R5 locked in reset", int'(locked), 0);
        rst = 1'b0;
    endtask

    task automatic t_toggle();
        apply_reset(2, 1'b1);
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            check(int'(test_out) == (i % 2), "R1 toggle", int'(test_out), i % 2);
        end
    endtask

    task automatic t_late_steps();
        apply_reset(1, 1'b1);
        repeat (3) @(negedge clk);
        check(int'(dac_code) == SAFE, "R3 no step before 4th edge", int'(dac_code), SAFE);
        @(negedge clk);
        check(int'(dac_code) == SAFE - 1, "R2 R3 first late step", int'(dac_code), SAFE - 1);
        repeat (12) @(negedge clk);
        check(int'(dac_code) == SAFE - 4, "R2 late steps down", int'(dac_code), SAFE - 4);
        repeat (40) @(negedge clk);
        check(int'(dac_code) == 0, "R4 floor", int'(dac_code), 0);
        repeat (20) @(negedge clk);
        check(int'(dac_code) == 0, "R4 floor holds", int'(dac_code), 0);
        check(locked == 1'b0, "R7 no lock when monotonic", int'(locked), 0);
    endtask

    task automatic t_early_sat();
        apply_reset(2, 1'b1);
        repeat (300) @(negedge clk);
        check(int'(dac_code) == CODE_TOP, "R4 ceiling", int'(dac_code), CODE_TOP);
        repeat (40) @(negedge clk);
        check(int'(dac_code) == CODE_TOP, "R4 ceiling holds", int'(dac_code), CODE_TOP);
        check(locked == 1'b0, "R7 no lock at ceiling", int'(locked), 0);
    endtask

    task automatic t_enable();
        apply_reset(2, 1'b0);
        repeat (60) @(negedge clk);
        check(int'(dac_code) == SAFE, "R6 frozen while disabled", int'(dac_code), SAFE);
        en = 1'b1;
        repeat (40) @(negedge clk);
        check(int'(dac_code) > SAFE, "R6 R2 steps up once enabled", int'(dac_code), SAFE + 1);
    endtask

    task automatic t_converge();
        int outside;
        int held;
        apply_reset(0, 1'b1);
        repeat (400) @(negedge clk);
        outside = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (int'(dac_code) != 45 && int'(dac_code) != 46) outside++;
        end
        check(outside == 0, "R8 dither within 45..46", outside, 0);
        check(locked == 1'b1, "R7 locked at equilibrium", int'(locked), 1);
        en   = 1'b0;
        mode = 1;
        @(negedge clk);
        held = int'(dac_code);
        repeat (40) @(negedge clk);
        check(int'(dac_code) == held, "R6 code held", int'(dac_code), held);
        check(locked == 1'b1, "R6 lock held", int'(locked), 1);
        en = 1'b1;
        repeat (16) @(negedge clk);
        check(locked == 1'b0, "R7 lock lost on same-direction steps", int'(locked), 0);
        check(int'(dac_code) < 45, "R2 late drives code down", int'(dac_code), 44);
    endtask

    initial begin
        t_reset_state();
        t_toggle();
        t_late_steps();
        t_early_sat();
        t_enable();
        t_converge();
        check(bad_steps == 0, "R3 unit steps, spaced", bad_steps, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule